// File: doc/BRIEF.md
# Up/Down/Centre-Aligned Timer with Four PWM Outputs

This block is the counting core of a general-purpose timer. A programmable prescaler divides the clock into ticks. A reload counter steps on those ticks in one of three patterns: upward, downward or centre-aligned (up then down). Four compare channels watch the count and drive PWM or hold-type outputs. An external trigger pin can act on the counter in a selectable slave mode: it can restart the count, gate it, or start it. Sticky event flags record update, trigger and per-channel compare events. Each flag has a mask bit toward a single interrupt line and a clear bit.

Software-facing registers live outside this core. The core takes the settings as plain input pins. Prescale, reload and compare values are double-buffered. While the counter is stopped they follow the pins. While it runs they are picked up only at the end of a counting period, so a period never sees a half-applied setting. All pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_timer_core`

## Requirements
- R1: While the counter runs and is not gated, each count value is held for exactly `psc`+1 clock cycles, so one up-count period with reload `arr` lasts (`arr`+1)·(`psc`+1) cycles.
- R2: With `count_down`=0 and `center_mode`=0, the count steps 0,1,…,`arr` and then returns to 0. That wrap is an update event and sets `flags[0]`. The count never exceeds the active reload value.
- R3: With `count_down`=1 and `center_mode`=0, the count steps from `arr` down to 0 and is then reloaded with `arr`, and the reload sets `flags[0]`. While the counter is stopped, `count` sits at its start value: `arr` when counting down, 0 otherwise. After reset `count`, `pwm_out`, `flags` and `irq` are all 0.
- R4: With `center_mode`=1, the count rises from 0 to `arr` and falls back to 0. Reaching `arr` and reaching 0 are both update events that set `flags[0]`.
- R5: Changes to `psc`, `arr` or a compare value made while the counter runs take effect only at the update that ends the current period. While the counter is stopped they take effect at once.
- R6: With `one_pulse`=1, the counter stops at the update that ends the first period and stays at its start value. It stays stopped until `enable` is dropped and raised again, or until a trigger edge arrives in trigger mode.
- R7: With `slave_en`=1 and `slave_mode`=1 (gate), the count advances only while `trig_in` is high and holds its value while `trig_in` is low.
- R8: With `slave_en`=1 and `slave_mode`=0 (reset), a rising edge on `trig_in` returns a running counter to its start value and restarts the prescaler. With `slave_en`=0, the trigger has no effect on the count.
- R9: With `slave_en`=1 and `slave_mode`=2 (trigger), an enabled counter waits for a rising edge on `trig_in` before it starts. With `one_pulse`=1, each later edge starts one more period.
- R10: Every rising edge of `trig_in` sets `flags[1]` when `slave_en`=1. It never sets the flag when `slave_en`=0.
- R11: Channel i uses compare bits [16i+15:16i] and mode bits [3i+2:3i]. In mode 6 its output is high while `count` is below the compare value. In mode 7 the output is the inverse of mode 6. A channel whose `ch_en` bit is 0 outputs 0.
- R12: Mode 0 freezes the channel output at its last level, and modes 2 to 5 behave like mode 0. Mode 1 toggles the output on each compare match.
- R13: A compare match occurs when the counter advances from a count equal to channel i's compare value. A match sets `flags[2+i]`, whether or not the channel is enabled.
- R14: Flags are sticky. A high `flag_clr` bit clears its flag at the next clock edge, but a new event in the same cycle wins over the clear. `irq` is the OR of `flags & irq_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Counter enable; low stops the counter and re-arms one-pulse |
| count_down | input | 1 | 0 up, 1 down (when not centre-aligned) |
| center_mode | input | 1 | Centre-aligned counting |
| one_pulse | input | 1 | Stop after one period |
| slave_en | input | 1 | Let the trigger input act on the counter |
| slave_mode | input | 2 | 0 reset, 1 gate, 2 trigger, 3 no action |
| trig_in | input | 1 | External trigger, synchronous to clk |
| psc | input | 16 | Prescale value, divide by psc+1 |
| arr | input | 16 | Reload value |
| cmp | input | 64 | Four compare values, channel i at [16i+15:16i] |
| ch_mode | input | 12 | Four output modes, channel i at [3i+2:3i] |
| ch_en | input | 4 | Per-channel output enable |
| irq_mask | input | 6 | Interrupt enable per flag |
| flag_clr | input | 6 | Clear strobe per flag |
| count | output | 16 | Current count |
| pwm_out | output | 4 | Channel outputs |
| flags | output | 6 | bit0 update, bit1 trigger, bit 2+i compare on channel i |
| irq | output | 1 | Masked OR of flags |

## Verification
An update event and a compare match can land on the same tick. This happens when a channel's compare value equals the reload value in up-counting, because the advance from `arr` both wraps the counter and leaves the matching count. The bench programs a compare value equal to `arr` and watches the sample taken just after the wrap. There, `count` must read 0, and `flags[0]` and `flags[3]` must both rise in that same sample. A second test holds a clear strobe high across a wrap, so the event must win for exactly one sample and then drop.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    OM_FREEZE    = 3'd0,
    OM_TOGGLE    = 3'd1,
    OM_PWM_BELOW = 3'd6,
    OM_PWM_ABOVE = 3'd7
  } out_mode_e;

  typedef enum logic [1:0] {
    SL_RESET   = 2'd0,
    SL_GATE    = 2'd1,
    SL_TRIGGER = 2'd2,
    SL_NONE    = 2'd3
  } slave_mode_e;

  localparam int FLG_UPDATE  = 0;
  localparam int FLG_TRIGGER = 1;
  localparam int FLG_CMP0    = 2;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] psc_in,
  input  logic         load,
  input  logic         clr,
  input  logic         cnt_en,
  output logic         tick
);
  logic [W-1:0] psc_sh, pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_sh <= '0;
      pre_q  <= '0;
    end else begin
      if (load) psc_sh <= psc_in;
      if (clr) pre_q <= '0;
      else if (cnt_en) pre_q <= (pre_q == psc_sh) ? '0 : pre_q + W'(1);
    end
  end

  assign tick = cnt_en && !clr && (pre_q == psc_sh);

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) pre_q <= psc_sh); // R1
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         count_down,
  input  logic         center_mode,
  input  logic         one_pulse,
  input  logic         slave_en,
  input  logic [1:0]   slave_mode,
  input  logic         trig_in,
  input  logic         trig_rise,
  input  logic         tick,
  input  logic [W-1:0] arr_in,
  output logic [W-1:0] cnt,
  output logic         pre_clr,
  output logic         cnt_en,
  output logic         shd_load,
  output logic         uev
);
  logic [W-1:0] cnt_q, arr_sh, cnt_nx, start_live, start_sh;
  logic run_q, done_q, cdir_q, cdir_nx, at_peak, at_end, uev_end;
  logic gate_mode, trig_mode, rst_mode, rst_evt;

  assign gate_mode = slave_en && (slave_mode == SL_GATE);
  assign trig_mode = slave_en && (slave_mode == SL_TRIGGER);
  assign rst_mode  = slave_en && (slave_mode == SL_RESET);
  assign rst_evt   = run_q && rst_mode && trig_rise;
  assign cnt_en    = run_q && (!gate_mode || trig_in);
  assign pre_clr   = !run_q || rst_evt;

  assign start_live = (count_down && !center_mode) ? arr_in : '0;
  assign start_sh   = (count_down && !center_mode) ? arr_sh : '0;

  always_comb begin
    cnt_nx  = cnt_q;
    cdir_nx = 1'b0;
    at_peak = 1'b0;
    at_end  = 1'b0;
    if (center_mode) begin
      cdir_nx = cdir_q;
      if (!cdir_q) begin
        if ({1'b0, cnt_q} + {{W{1'b0}}, 1'b1} >= {1'b0, arr_sh}) begin
          cnt_nx  = arr_sh;
          cdir_nx = 1'b1;
          at_peak = 1'b1;
        end else cnt_nx = cnt_q + W'(1);
      end else begin
        if (cnt_q <= W'(1)) begin
          cnt_nx  = '0;
          cdir_nx = 1'b0;
          at_end  = 1'b1;
        end else cnt_nx = cnt_q - W'(1);
      end
    end else if (count_down) begin
      if (cnt_q == '0) begin
        cnt_nx = arr_in;
        at_end = 1'b1;
      end else cnt_nx = cnt_q - W'(1);
    end else begin
      if (cnt_q >= arr_sh) begin
        cnt_nx = '0;
        at_end = 1'b1;
      end else cnt_nx = cnt_q + W'(1);
    end
  end

  assign uev_end  = tick && at_end;
  assign uev      = tick && (at_end || at_peak);
  assign shd_load = !run_q || uev_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      arr_sh <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cdir_q <= 1'b0;
    end else begin
      if (shd_load) arr_sh <= arr_in;
      if (!enable) begin
        run_q  <= 1'b0;
        done_q <= 1'b0;
      end else if (uev_end && one_pulse) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end else if (!run_q && (trig_mode ? trig_rise : !done_q)) begin
        run_q <= 1'b1;
      end
      if (!run_q) begin
        cnt_q  <= start_live;
        cdir_q <= 1'b0;
      end else if (rst_evt) begin
        cnt_q  <= start_sh;
        cdir_q <= 1'b0;
      end else if (tick) begin
        cnt_q  <= cnt_nx;
        cdir_q <= cdir_nx;
      end
    end
  end

  assign cnt = cnt_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= arr_sh); // R2
  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (run_q && enable && gate_mode && !trig_in) |=> $stable(cnt_q)); // R7
  AST_ONE_PULSE_STOP: assert property (@(posedge clk) disable iff (!rst_n) (enable && one_pulse && uev_end) |=> !run_q); // R6
  AST_TRIG_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (trig_mode && !run_q && !trig_rise) |=> !run_q); // R9
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cmp_in,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] cnt,
  input  logic         ch_en,
  input  logic [2:0]   mode,
  output logic         match,
  output logic         pwm
);
  logic [W-1:0] cmp_sh;
  logic hold_q, below, is_pwm, is_hold, level;

  assign below   = cnt < cmp_sh;
  assign match   = adv && (cnt == cmp_sh);
  assign is_pwm  = (mode == OM_PWM_BELOW) || (mode == OM_PWM_ABOVE);
  assign is_hold = !is_pwm && (mode != OM_TOGGLE);
  assign level   = (mode == OM_PWM_BELOW) ? below : (mode == OM_PWM_ABOVE) ? !below : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_sh <= '0;
      hold_q <= 1'b0;
    end else begin
      if (load) cmp_sh <= cmp_in;
      if (!ch_en) hold_q <= 1'b0;
      else if (is_pwm) hold_q <= level;
      else if (mode == OM_TOGGLE && match) hold_q <= !hold_q;
    end
  end

  assign pwm = ch_en && level;

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (ch_en && is_hold && $past(ch_en && is_hold)) |-> $stable(pwm)); // R12
endmodule

// File: rtl/pwm_timer_core.sv
module pwm_timer_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CH  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  count_down,
  input  logic                  center_mode,
  input  logic                  one_pulse,
  input  logic                  slave_en,
  input  logic [1:0]            slave_mode,
  input  logic                  trig_in,
  input  logic [CNT_W-1:0]      psc,
  input  logic [CNT_W-1:0]      arr,
  input  logic [N_CH*CNT_W-1:0] cmp,
  input  logic [N_CH*3-1:0]     ch_mode,
  input  logic [N_CH-1:0]       ch_en,
  input  logic [N_CH+1:0]       irq_mask,
  input  logic [N_CH+1:0]       flag_clr,
  output logic [CNT_W-1:0]      count,
  output logic [N_CH-1:0]       pwm_out,
  output logic [N_CH+1:0]       flags,
  output logic                  irq
);
  localparam int NF = N_CH + 2;

  logic trig_q, trig_rise, tick, pre_clr, cnt_en, shd_load, uev;
  logic [CNT_W-1:0] cnt;
  logic [N_CH-1:0] match;
  logic [NF-1:0] flag_set, flag_q;

  assign trig_rise = trig_in && !trig_q;

  tmr_prescaler #(.W(CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .psc_in(psc), .load(shd_load),
    .clr(pre_clr), .cnt_en(cnt_en), .tick(tick)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .count_down(count_down),
    .center_mode(center_mode), .one_pulse(one_pulse), .slave_en(slave_en),
    .slave_mode(slave_mode), .trig_in(trig_in), .trig_rise(trig_rise),
    .tick(tick), .arr_in(arr), .cnt(cnt), .pre_clr(pre_clr),
    .cnt_en(cnt_en), .shd_load(shd_load), .uev(uev)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    tmr_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cmp_in(cmp[i*CNT_W +: CNT_W]), .load(shd_load),
      .adv(tick), .cnt(cnt), .ch_en(ch_en[i]), .mode(ch_mode[i*3 +: 3]),
      .match(match[i]), .pwm(pwm_out[i])
    );
  end

  assign flag_set[FLG_UPDATE]           = uev;
  assign flag_set[FLG_TRIGGER]          = slave_en && trig_rise;
  assign flag_set[NF-1:FLG_CMP0]        = match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      flag_q <= '0;
    end else begin
      trig_q <= trig_in;
      flag_q <= (flag_q & ~flag_clr) | flag_set;
    end
  end

  assign count = cnt;
  assign flags = flag_q;
  assign irq   = |(flag_q & irq_mask);

  for (genvar f = 0; f < NF; f++) begin : g_fchk
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) flag_set[f] |=> flag_q[f]); // R14
  end
endmodule

// File: tb/pwm_timer_core_test.sv
module pwm_timer_core_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable, count_down, center_mode, one_pulse, slave_en, trig_in;
  logic [1:0] slave_mode;
  logic [15:0] psc, arr, count;
  logic [63:0] cmp;
  logic [11:0] ch_mode;
  logic [3:0] ch_en, pwm_out;
  logic [5:0] irq_mask, flag_clr, flags;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pwm_timer_core uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .count_down(count_down),
    .center_mode(center_mode), .one_pulse(one_pulse), .slave_en(slave_en),
    .slave_mode(slave_mode), .trig_in(trig_in), .psc(psc), .arr(arr), .cmp(cmp),
    .ch_mode(ch_mode), .ch_en(ch_en), .irq_mask(irq_mask), .flag_clr(flag_clr),
    .count(count), .pwm_out(pwm_out), .flags(flags), .irq(irq)
  );

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_count(input int v, input string r);
    int k = 0;
    while (count != v && k < 3000) begin step(); k++; end
    chk(r, count, v);
  endtask

  task automatic cycles_to(input int v, output int n);
    n = 0;
    do begin step(); n++; end while (count != v && n < 3000);
  endtask

  task automatic defaults();
    enable = 0; count_down = 0; center_mode = 0; one_pulse = 0; slave_en = 0;
    slave_mode = 2'd3; trig_in = 0; psc = 0; arr = 0; cmp = '0; ch_mode = '0;
    ch_en = '0; irq_mask = '0; flag_clr = '0;
  endtask

  task automatic idle();
    defaults();
    flag_clr = '1;
    step(2);
    flag_clr = '0;
    step();
  endtask

  task automatic t_reset();
    chk("R3 reset count", count, 0);
    chk("R3 reset pwm", pwm_out, 0);
    chk("R3 reset flags", flags, 0);
    chk("R3 reset irq", irq, 0);
  endtask

  task automatic t_up();
    int n, a, b;
    idle(); psc = 2; arr = 4; enable = 1;
    wait_count(1, "R1 start");
    cycles_to(2, n);
    chk("R1 value held psc+1", n, 3);
    wait_count(4, "R2 reaches arr");
    chk("R2 no update before wrap", flags[0], 0);
    cycles_to(0, n);
    chk("R2 wraps to 0", count, 0);
    chk("R2 update flag at wrap", flags[0], 1);
    cycles_to(4, a); cycles_to(0, b);
    chk("R1 period length", a + b, 15);
  endtask

  task automatic t_down();
    idle(); count_down = 1; arr = 5; step(2);
    chk("R3 stopped at arr", count, 5);
    enable = 1;
    wait_count(0, "R3 reaches 0");
    step();
    chk("R3 reload to arr", count, 5);
    chk("R3 update on reload", flags[0], 1);
    step();
    chk("R3 counts down", count, 4);
  endtask

  task automatic t_center();
    idle(); center_mode = 1; arr = 3; enable = 1;
    wait_count(3, "R4 reaches peak");
    chk("R4 update at peak", flags[0], 1);
    flag_clr[0] = 1; step(); flag_clr[0] = 0;
    chk("R4 falls after peak", count, 2);
    chk("R14 clear strobe", flags[0], 0);
    step(2);
    chk("R4 reaches 0", count, 0);
    chk("R4 update at valley", flags[0], 1);
    step();
    chk("R4 rises again", count, 1);
  endtask

  task automatic t_pwm();
    int e0 = 0, e1 = 0, e3 = 0;
    idle(); arr = 9;
    cmp[15:0] = 4; cmp[31:16] = 4; cmp[63:48] = 4;
    ch_mode[2:0] = 3'd6; ch_mode[5:3] = 3'd7; ch_mode[11:9] = 3'd6;
    ch_en = 4'b0011; enable = 1; step(2);
    for (int i = 0; i < 25; i++) begin
      if (pwm_out[0] != (count < 4)) e0++;
      if (pwm_out[1] != (count >= 4)) e1++;
      if (pwm_out[3] != 1'b0) e3++;
      step();
    end
    chk("R11 mode 6 below compare", e0, 0);
    chk("R11 mode 7 inverse", e1, 0);
    chk("R11 disabled channel low", e3, 0);
  endtask

  task automatic t_hold_toggle();
    int e0 = 0, e1 = 0, tr = 0;
    logic prev;
    idle(); arr = 9;
    cmp[15:0] = 4; cmp[31:16] = 4; cmp[47:32] = 2;
    ch_mode[2:0] = 3'd6; ch_mode[5:3] = 3'd6; ch_mode[8:6] = 3'd1;
    ch_en = 4'b0111; enable = 1;
    step(2);
    wait_count(2, "R12 setup");
    ch_mode[2:0] = 3'd0; ch_mode[5:3] = 3'd5;
    for (int i = 0; i < 20; i++) begin
      step();
      if (pwm_out[0] != 1'b1) e0++;
      if (pwm_out[1] != 1'b1) e1++;
    end
    chk("R12 freeze holds high", e0, 0);
    chk("R12 reserved code holds", e1, 0);
    prev = pwm_out[2];
    for (int i = 0; i < 30; i++) begin
      step();
      if (pwm_out[2] != prev) tr++;
      prev = pwm_out[2];
    end
    chk("R12 toggle once per period", tr, 3);
  endtask

  task automatic t_cmp_flags();
    idle(); arr = 9; cmp[15:0] = 4; cmp[31:16] = 9; enable = 1;
    step();
    wait_count(4, "R13 setup");
    chk("R13 no flag before match", flags[2], 0);
    step();
    chk("R13 count after match", count, 5);
    chk("R13 match flag ch0", flags[2], 1);
    wait_count(9, "R13 setup ch1");
    chk("R13 ch1 flag not early", flags[3], 0);
    step();
    chk("R2 wrap with match", count, 0);
    chk("R13 ch1 flag with update", flags[3], 1);
    chk("R2 update with match", flags[0], 1);
  endtask

  task automatic t_shadow();
    idle(); arr = 9; cmp[15:0] = 4; ch_mode[2:0] = 3'd6; ch_en = 4'b0001; enable = 1;
    step();
    wait_count(6, "R5 setup");
    cmp[15:0] = 8; arr = 5;
    step();
    chk("R5 count continues", count, 7);
    chk("R5 old compare kept", pwm_out[0], 0);
    wait_count(9, "R5 old reload kept");
    step();
    chk("R5 wrap after old reload", count, 0);
    wait_count(5, "R5 new period");
    chk("R5 new compare active", pwm_out[0], 1);
    step();
    chk("R5 new reload active", count, 0);
  endtask

  task automatic t_one_pulse();
    int e = 0;
    idle(); arr = 3; psc = 1; one_pulse = 1; enable = 1;
    wait_count(3, "R6 runs");
    wait_count(0, "R6 wraps");
    for (int i = 0; i < 20; i++) begin step(); if (count != 0) e++; end
    chk("R6 stays stopped", e, 0);
    chk("R6 update recorded", flags[0], 1);
    enable = 0; step(2); enable = 1;
    wait_count(2, "R6 rearm by enable");
  endtask

  task automatic t_gate();
    int e = 0, v;
    idle(); slave_en = 1; slave_mode = 2'd1; arr = 20; enable = 1;
    step(10);
    chk("R7 gated off", count, 0);
    trig_in = 1;
    wait_count(3, "R7 runs when high");
    trig_in = 0; v = count;
    for (int i = 0; i < 6; i++) begin step(); if (count != v) e++; end
    chk("R7 holds when low", e, 0);
  endtask

  task automatic t_reset_mode();
    idle(); slave_en = 1; slave_mode = 2'd0; arr = 200; enable = 1;
    wait_count(50, "R8 setup");
    trig_in = 1; step(); trig_in = 0;
    chk("R8 trigger clears count", count, 0);
    chk("R10 trigger flag", flags[1], 1);
    step();
    chk("R8 restarts", count, 1);
    flag_clr = 6'b000010; step(); flag_clr = '0; slave_en = 0;
    wait_count(80, "R8 setup 2");
    trig_in = 1; step(); trig_in = 0;
    chk("R8 ignored without slave", count, 81);
    chk("R10 no flag without slave", flags[1], 0);
  endtask

  task automatic t_trigger();
    int e = 0;
    idle(); slave_en = 1; slave_mode = 2'd2; one_pulse = 1; arr = 3; enable = 1;
    for (int i = 0; i < 8; i++) begin step(); if (count != 0) e++; end
    chk("R9 waits for edge", e, 0);
    trig_in = 1; step(); trig_in = 0;
    wait_count(3, "R9 starts on edge");
    wait_count(0, "R9 period ends");
    e = 0;
    for (int i = 0; i < 6; i++) begin step(); if (count != 0) e++; end
    chk("R9 one pulse stops", e, 0);
    trig_in = 1; step(); trig_in = 0;
    wait_count(2, "R9 retrigger");
  endtask

  task automatic t_irq();
    idle(); arr = 3; enable = 1;
    wait_count(3, "R14 setup");
    step();
    chk("R14 flag set", flags[0], 1);
    chk("R14 masked irq", irq, 0);
    irq_mask = 6'b000001; #1;
    chk("R14 unmasked irq", irq, 1);
    flag_clr[0] = 1;
    step();
    wait_count(3, "R14 setup 2");
    chk("R14 held clear", flags[0], 0);
    step();
    chk("R14 event wins over clear", flags[0], 1);
    step();
    chk("R14 clear after event", flags[0], 0);
    flag_clr = '0; irq_mask = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    defaults();
    step(3);
    rst_n = 1;
    step();
    t_reset();
    t_up();
    t_down();
    t_center();
    t_pwm();
    t_hold_toggle();
    t_cmp_flags();
    t_shadow();
    t_one_pulse();
    t_gate();
    t_reset_mode();
    t_trigger();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule